// File: doc/BRIEF.md
# Sprite Attribute Memory Page Copy Engine

This block holds the 256-byte sprite attribute memory of a video controller, together with the two CPU-visible ports used to reach it: a pointer register that selects a byte, and a data port that reads or writes the selected byte. A third CPU register starts a bulk copy. When the CPU writes a page number N to it, the engine halts the CPU. It then copies the 256 bytes at CPU addresses N*256 to N*256+255 into sprite memory. Each byte goes through the same write path as the data port, so the copy begins at the live pointer value and wraps around the memory.

A copy first spends one idle wait cycle. If the trigger arrived on an odd bus phase, it spends one more alignment cycle. After that it runs 256 pairs of cycles: one read of CPU memory, then one write into sprite memory. Outside the copy engine, two timing inputs from the raster logic shape the behaviour. While rendering is active, writes do not reach the memory. A raster request can also force the pointer to zero.

Top module: `spr_dma_top`

## Requirements
- R1: A write with `reg_sel`=2 and value N starts a copy that asserts `bus_rd` in 256 read cycles, with `bus_addr` = {N, i} for i = 0, 1, ..., 255 in that order.
- R2: `cpu_halt` rises in the cycle after the trigger write and stays high for 513 cycles if `phase_odd` was 0 at the trigger, or 514 cycles if it was 1. It falls in the cycle after the last sprite memory write. Read cycles and write cycles alternate, and no two read cycles are adjacent.
- R3: Byte i of the copied page is stored at sprite address (P+i) mod 256, where P is the pointer when the copy starts. After the copy, the pointer equals P again.
- R4: A write with `reg_sel`=1 stores `reg_wdata` at the pointer, and the pointer then advances by one, wrapping from 255 to 0. A read with `reg_sel`=1 returns the byte at the pointer on `reg_rdata` in the same cycle and leaves the pointer unchanged.
- R5: A write with `reg_sel`=0 loads `reg_wdata` into the pointer.
- R6: While `render_active` is 1, data-port writes leave sprite memory unchanged and `spr_we` stays 0, but the pointer still advances.
- R7: When `ptr_zero` is 1 at a clock edge, the pointer becomes 0, and this takes priority over a pointer load or an advance in the same cycle.
- R8: While `cpu_halt` is 1, every register write is ignored, including a further trigger. The running copy keeps its page and its length.
- R9: After reset, `cpu_halt`, `bus_rd` and `spr_we` are 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | CPU register write strobe |
| reg_rd | input | 1 | CPU register read strobe |
| reg_sel | input | 2 | Register select: 0 pointer, 1 data port, 2 copy trigger, 3 unused |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Byte at the pointer (data-port read value) |
| phase_odd | input | 1 | 1 when the current bus cycle is an odd (put) cycle |
| render_active | input | 1 | Raster is fetching; sprite memory writes are dropped |
| ptr_zero | input | 1 | Raster request to force the pointer to 0 |
| bus_rdata | input | 8 | CPU memory data returned for a copy read |
| cpu_halt | output | 1 | Holds the CPU while a copy runs |
| bus_rd | output | 1 | Copy read strobe on the CPU bus |
| bus_addr | output | 16 | Copy read address on the CPU bus |
| spr_we | output | 1 | Sprite memory write taking effect this cycle |
| spr_waddr | output | 8 | Sprite memory write address |
| spr_wdata | output | 8 | Sprite memory write data |

## Verification
A data-port read result is combinational and is sampled 1 ns after the inputs are driven. A pointer or memory update is due at the next rising edge and is observed through a data-port read in a later cycle. `cpu_halt` is due one edge after the trigger. The bench samples it on every falling edge from then on, counts the halted cycles against 513 or 514, and compares each `bus_addr` seen with `bus_rd` high against the next expected page offset. Copied contents are checked after the halt has fallen, by loading each address and reading it back.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

  localparam int unsigned PTR_W  = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned PAGE_W = 8;

  localparam logic [1:0] SEL_PTR  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_TRIG = 2'd2;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_ALIGN,
    SQ_GET,
    SQ_PUT
  } sq_state_e;

  // CPU address of byte idx within page pg
  function automatic logic [PAGE_W+PTR_W-1:0] page_addr(
      input logic [PAGE_W-1:0] pg, input logic [PTR_W-1:0] idx);
    return {pg, idx};
  endfunction

  // wrapping pointer advance
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

endpackage

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
  import spr_dma_pkg::*;
#(
  parameter int unsigned PG_W  = PAGE_W,
  parameter int unsigned IX_W  = PTR_W,
  parameter int unsigned DW    = DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PG_W-1:0]    page_i,
  input  logic               odd_i,
  input  logic [DW-1:0]      bus_rdata_i,
  output logic               busy_o,
  output logic               bus_rd_o,
  output logic [PG_W+IX_W-1:0] bus_addr_o,
  output logic               put_o,
  output logic [DW-1:0]      put_data_o
);

  localparam logic [IX_W-1:0] IX_LAST = {IX_W{1'b1}};

  sq_state_e         state_q;
  logic [PG_W-1:0]   page_q;
  logic [IX_W-1:0]   idx_q;
  logic [DW-1:0]     data_q;
  logic              align_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      page_q  <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      align_q <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          page_q  <= page_i;
          align_q <= odd_i;
          idx_q   <= '0;
          state_q <= SQ_WAIT;
        end
        SQ_WAIT:  state_q <= align_q ? SQ_ALIGN : SQ_GET;
        SQ_ALIGN: state_q <= SQ_GET;
        SQ_GET: begin
          data_q  <= bus_rdata_i;
          state_q <= SQ_PUT;
        end
        SQ_PUT: begin
          idx_q   <= idx_q + IX_W'(1);
          state_q <= (idx_q == IX_LAST) ? SQ_IDLE : SQ_GET;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != SQ_IDLE);
  assign bus_rd_o   = (state_q == SQ_GET);
  assign bus_addr_o = page_addr(page_q, idx_q);
  assign put_o      = (state_q == SQ_PUT);
  assign put_data_o = data_q;

endmodule

// File: rtl/spr_ptr_reg.sv
module spr_ptr_reg
  import spr_dma_pkg::*;
#(
  parameter int unsigned W = PTR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] ptr_o
);

  logic [W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (zero_i)  ptr_q <= '0;
    else if (load_i)  ptr_q <= load_val_i;
    else if (inc_i)   ptr_q <= ptr_q + W'(1);
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/spr_attr_mem.sv
module spr_attr_mem #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/spr_dma_top.sv
module spr_dma_top
  import spr_dma_pkg::*;
#(
  parameter int unsigned AW  = PTR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned PGW = PAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [1:0]         reg_sel,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic               phase_odd,
  input  logic               render_active,
  input  logic               ptr_zero,
  input  logic [DW-1:0]      bus_rdata,
  output logic               cpu_halt,
  output logic               bus_rd,
  output logic [PGW+AW-1:0]  bus_addr,
  output logic               spr_we,
  output logic [AW-1:0]      spr_waddr,
  output logic [DW-1:0]      spr_wdata
);

  // named internal events (also observed by the checker)
  logic          busy;
  logic          trig_go;
  logic          ptr_load;
  logic          port_wr;
  logic          port_rd;
  logic          put;
  logic [DW-1:0] put_data;
  logic          wr_evt;
  logic [DW-1:0] wr_data;
  logic          mem_we;
  logic [AW-1:0] ptr_q;

  assign trig_go  = reg_wr && (reg_sel == SEL_TRIG) && !busy;
  assign ptr_load = reg_wr && (reg_sel == SEL_PTR)  && !busy;
  assign port_wr  = reg_wr && (reg_sel == SEL_DATA) && !busy;
  assign port_rd  = reg_rd && (reg_sel == SEL_DATA);

  spr_dma_seq #(.PG_W(PGW), .IX_W(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (trig_go),
    .page_i     (reg_wdata[PGW-1:0]),
    .odd_i      (phase_odd),
    .bus_rdata_i(bus_rdata),
    .busy_o     (busy),
    .bus_rd_o   (bus_rd),
    .bus_addr_o (bus_addr),
    .put_o      (put),
    .put_data_o (put_data)
  );

  // copy writes and port writes share one path; they never coincide
  assign wr_evt  = put || port_wr;
  assign wr_data = put ? put_data : reg_wdata;
  assign mem_we  = wr_evt && !render_active;

  spr_ptr_reg #(.W(AW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .zero_i    (ptr_zero),
    .load_i    (ptr_load),
    .load_val_i(reg_wdata[AW-1:0]),
    .inc_i     (wr_evt),
    .ptr_o     (ptr_q)
  );

  spr_attr_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk    (clk),
    .we_i   (mem_we),
    .waddr_i(ptr_q),
    .wdata_i(wr_data),
    .raddr_i(ptr_q),
    .rdata_o(reg_rdata)
  );

  assign cpu_halt  = busy;
  assign spr_we    = mem_we;
  assign spr_waddr = ptr_q;
  assign spr_wdata = wr_data;

endmodule

// File: rtl/spr_dma_chk.sv
module spr_dma_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig_go,
  input logic          ptr_load,
  input logic          port_rd,
  input logic          wr_evt,
  input logic          ptr_zero,
  input logic          render_active,
  input logic          cpu_halt,
  input logic          bus_rd,
  input logic          spr_we,
  input logic [AW-1:0] ptr
);

  AST_HALT_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_go |=> cpu_halt); // R2

  AST_RD_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> cpu_halt); // R1

  AST_RD_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd); // R2

  AST_NO_TRIG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> !trig_go && !ptr_load); // R8

  AST_RENDER_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    render_active |-> !spr_we); // R6

  AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_zero |=> ptr == '0); // R7

  AST_WRITE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && !ptr_zero |=> ptr == AW'($past(ptr) + AW'(1))); // R4

  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd && !wr_evt && !ptr_load && !ptr_zero |=> $stable(ptr)); // R4

endmodule

bind spr_dma_top spr_dma_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_go      (trig_go),
  .ptr_load     (ptr_load),
  .port_rd      (port_rd),
  .wr_evt       (wr_evt),
  .ptr_zero     (ptr_zero),
  .render_active(render_active),
  .cpu_halt     (cpu_halt),
  .bus_rd       (bus_rd),
  .spr_we       (spr_we),
  .ptr          (ptr_q)
);

// File: tb/spr_dma_top_bench.sv
`timescale 1ns/1ps
module spr_dma_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        phase_odd = 1'b0, render_active = 1'b0, ptr_zero = 1'b0;
  logic [7:0]  bus_rdata;
  logic        cpu_halt, bus_rd, spr_we;
  logic [15:0] bus_addr;
  logic [7:0]  spr_waddr, spr_wdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  spr_dma_top u_spr_dma_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .phase_odd(phase_odd), .render_active(render_active), .ptr_zero(ptr_zero),
    .bus_rdata(bus_rdata), .cpu_halt(cpu_halt), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .spr_we(spr_we), .spr_waddr(spr_waddr),
    .spr_wdata(spr_wdata)
  );

  // CPU memory model: content is a fixed mix of the address bytes
  function automatic logic [7:0] cpu_byte(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
  endfunction

  assign bus_rdata = cpu_byte(bus_addr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic cpu_wr(input logic [1:0] sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cpu_rd(output logic [7:0] d);
    reg_rd = 1'b1; reg_sel = 2'd1;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // stimulus/expected vectors: {page, start pointer, odd phase, retrigger, halt length}
  localparam int NV = 4;
  localparam logic [27:0] VEC [NV] = '{
    {8'h02, 8'h00, 1'b0, 1'b0, 10'd513},
    {8'h7F, 8'h10, 1'b1, 1'b0, 10'd514},
    {8'hC3, 8'hFF, 1'b0, 1'b1, 10'd513},
    {8'h05, 8'h81, 1'b1, 1'b1, 10'd514}
  };

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: idle outputs after reset
    check(!cpu_halt && !bus_rd && !spr_we, "R9 idle after reset",
          {cpu_halt, bus_rd, spr_we}, 0);
    // R9: pointer starts at 0 -> port write lands at byte 0
    cpu_wr(2'd1, 8'hA5);
    cpu_wr(2'd0, 8'h00);
    cpu_rd(rd);
    check(rd == 8'hA5, "R9 pointer reset to zero", rd, 8'hA5);

    // table walk of copy runs
    for (int v = 0; v < NV; v++) begin
      logic [7:0] pg, st;
      logic       odd, retrig;
      int         exp_len, hcnt, ridx, amiss, dmiss;
      {pg, st, odd, retrig, exp_len} = {VEC[v][27:10], 22'(VEC[v][9:0])};
      pg = VEC[v][27:20]; st = VEC[v][19:12]; odd = VEC[v][11];
      retrig = VEC[v][10]; exp_len = int'(VEC[v][9:0]);
      cpu_wr(2'd0, st);
      reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = pg; phase_odd = odd;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0; phase_odd = 1'b0;
      hcnt = 0; ridx = 0; amiss = 0;
      while (cpu_halt && hcnt < 1000) begin
        hcnt++;
        if (bus_rd) begin
          if (bus_addr != {pg, 8'(ridx)}) amiss++;
          if (bus_rd && ridx > 0 && hcnt == 0) amiss++;
          ridx++;
        end
        if (retrig && hcnt == 100) begin
          reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = ~pg;
        end else begin
          reg_wr = 1'b0;
        end
        @(negedge clk);
      end
      reg_wr = 1'b0;
      check(hcnt == exp_len, "R2 halt length", hcnt, exp_len);
      check(amiss == 0 && ridx == 256, "R1 read address order", ridx, 256);
      if (retrig) check(amiss == 0 && hcnt == exp_len, "R8 trigger while busy ignored", hcnt, exp_len);
      // pointer back at start: read without reloading
      cpu_rd(rd);
      check(rd == cpu_byte({pg, 8'h00}), "R3 pointer returns to start", rd, cpu_byte({pg, 8'h00}));
      dmiss = 0;
      for (int i = 0; i < 256; i++) begin
        cpu_wr(2'd0, 8'(st + 8'(i)));
        cpu_rd(rd);
        if (rd != cpu_byte({pg, 8'(i)})) dmiss++;
      end
      check(dmiss == 0, "R3 copied bytes wrap from start pointer", dmiss, 0);
    end

    // R4: write stores then advances, read does not advance
    cpu_wr(2'd0, 8'h40);
    cpu_wr(2'd1, 8'h11);
    cpu_wr(2'd1, 8'h22);
    cpu_wr(2'd0, 8'h40);
    cpu_rd(rd);
    check(rd == 8'h11, "R4 first port write", rd, 8'h11);
    cpu_rd(rd);
    check(rd == 8'h11, "R4 read leaves pointer", rd, 8'h11);
    cpu_wr(2'd0, 8'h41);
    cpu_rd(rd);
    check(rd == 8'h22, "R5 pointer load selects byte", rd, 8'h22);
    // R4 wrap 255 -> 0
    cpu_wr(2'd0, 8'hFF);
    cpu_wr(2'd1, 8'h77);
    cpu_wr(2'd1, 8'h88);
    cpu_wr(2'd0, 8'h00);
    cpu_rd(rd);
    check(rd == 8'h88, "R4 pointer wraps to zero", rd, 8'h88);

    // R6: writes during rendering dropped, pointer advances
    render_active = 1'b1;
    cpu_wr(2'd0, 8'h40);
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h99;
    #1 check(!spr_we, "R6 no write strobe while rendering", spr_we, 0);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    render_active = 1'b0;
    cpu_wr(2'd1, 8'h66);
    cpu_wr(2'd0, 8'h40);
    cpu_rd(rd);
    check(rd == 8'h11, "R6 byte unchanged by render write", rd, 8'h11);
    cpu_wr(2'd0, 8'h41);
    cpu_rd(rd);
    check(rd == 8'h66, "R6 pointer advanced during render", rd, 8'h66);

    // R7: zero request beats a simultaneous pointer load
    ptr_zero = 1'b1;
    cpu_wr(2'd0, 8'h20);
    ptr_zero = 1'b0;
    cpu_wr(2'd1, 8'h6C);
    cpu_wr(2'd0, 8'h00);
    cpu_rd(rd);
    check(rd == 8'h6C, "R7 zero request wins over load", rd, 8'h6C);
    // R7: zero request alone
    cpu_wr(2'd0, 8'h55);
    ptr_zero = 1'b1;
    @(posedge clk); @(negedge clk);
    ptr_zero = 1'b0;
    cpu_rd(rd);
    check(rd == 8'h6C, "R7 zero request alone", rd, 8'h6C);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule